// File: doc/BRIEF.md
# Split Four-Bit Ripple Binary Counter

This block is a four-bit binary counter built from two sections that run independently. A divide-by-two section toggles the low output bit. A divide-by-eight section steps the three upper output bits through a binary count. Each section has its own count input. A count happens on the high-to-low transition of that input, as seen by the single system clock.

A mode input can chain the sections internally. In chained mode, each falling edge of the low output bit becomes the strobe for the upper section, so the four bits form one modulo-16 count. Two clear inputs are ANDed together. The outputs go to zero only while both are high.

Everything runs on one clock with a synchronous, active-high reset. A count input is sampled once per clock. The input can therefore produce at most one falling edge every two clocks.

Top module: `split_ripple_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `q_o` becomes 0 after that edge. The edge history of both count inputs also becomes low.
- R2: `q_o[0]` inverts at the rising edge where `cnt_a_i` is sampled low after being sampled high at the previous edge. At every other edge `q_o[0]` keeps its value.
- R3: With `chain_i` = 0, `q_o[3:1]` increments by one at the edge where `cnt_b_i` is sampled low after being high. It wraps from 7 to 0. At every other edge it holds.
- R4: With `chain_i` = 1, `q_o[3:1]` increments one clock after `q_o[0]` goes from 1 to 0. Pulses on `cnt_a_i` then step `q_o` from 0 to 15 in binary and wrap to 0.
- R5: When `clr_x_i` and `clr_y_i` are both high at an edge, `q_o` becomes 0. When only one of them is high, counting goes on normally.
- R6: Count edges sampled while the clear is active are discarded. A clear that drops `q_o[0]` from 1 to 0 does not step the upper section in chained mode.
- R7: With `chain_i` = 1, `cnt_b_i` has no effect. With `chain_i` = 0, changes of `q_o[0]` do not affect `q_o[3:1]`.
- R8: Both count inputs may toggle on every clock. Each high-to-low transition seen at that rate is counted, with none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_a_i | input | 1 | Count input of the divide-by-two section |
| cnt_b_i | input | 1 | Count input of the divide-by-eight section (split mode) |
| clr_x_i | input | 1 | First clear input, ANDed with `clr_y_i` |
| clr_y_i | input | 1 | Second clear input, ANDed with `clr_x_i` |
| chain_i | input | 1 | 0: sections independent; 1: low bit drives upper section |
| q_o | output | 4 | Count; bit 0 is the divide-by-two output, bits 3:1 the divide-by-eight count |

## Verification
Pulse trains of known length go into each count input in split mode. The resulting counts are checked arithmetically, which separates toggling from counting and shows the wrap from 7 to 0. In chained mode, the count after every pulse must equal the pulse number modulo 16, which exposes a missing or doubled forward from the low bit. Inputs toggling on every clock show that no edge is lost at the highest rate. Single-sided and two-sided clears with edges inside them separate the AND gating from an OR, and show that edges during a clear are discarded. A long random run with random clears and mode switches is compared clock by clock against a model in the bench.

// File: rtl/src_pkg.sv
package src_pkg;

    localparam int unsigned SRC_HI_W_DEF = 3;

    typedef enum logic {
        SRC_SPLIT = 1'b0,
        SRC_CHAIN = 1'b1
    } src_mode_e;

    typedef struct packed {
        logic fall_a;
        logic fall_b;
        logic fall_q;
    } src_edges_t;

    typedef struct packed {
        logic lo_stb;
        logic hi_stb;
        logic clear;
    } src_ctrl_t;

    function automatic logic src_clear(input logic x, input logic y);
        return x & y;
    endfunction

    function automatic src_ctrl_t src_decode(input src_mode_e mode,
                                             input src_edges_t e,
                                             input logic clr);
        src_ctrl_t c;
        c.clear  = clr;
        c.lo_stb = e.fall_a & ~clr;
        c.hi_stb = ((mode == SRC_CHAIN) ? e.fall_q : e.fall_b) & ~clr;
        return c;
    endfunction

endpackage

// File: rtl/src_fall_det.sv
module src_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic flush_i,
    input  logic din_i,
    output logic fall_o
);
    logic hist_q;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            hist_q <= 1'b0;
        end else begin
            hist_q <= din_i;
        end
    end

    assign fall_o = hist_q & ~din_i;
endmodule

// File: rtl/src_toggle_stage.sv
module src_toggle_stage (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic stb_i,
    output logic q_o
);
    logic q_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            q_q <= 1'b0;
        end else if (stb_i) begin
            q_q <= ~q_q;
        end
    end

    assign q_o = q_q;
endmodule

// File: rtl/src_wrap_counter.sv
module src_wrap_counter #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         stb_i,
    output logic [W-1:0] q_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] q_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            q_q <= '0;
        end else if (stb_i) begin
            q_q <= q_q + ONE;
        end
    end

    assign q_o = q_q;
endmodule

// File: rtl/split_ripple_counter.sv
module split_ripple_counter
    import src_pkg::*;
#(
    parameter int unsigned HI_W = SRC_HI_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cnt_a_i,
    input  logic            cnt_b_i,
    input  logic            clr_x_i,
    input  logic            clr_y_i,
    input  logic            chain_i,
    output logic [HI_W:0]   q_o
);
    localparam int unsigned Q_W  = HI_W + 1;
    localparam int unsigned N_IN = 2;

    logic [N_IN-1:0] ext_in;
    logic [N_IN-1:0] ext_fall;
    logic            clr;
    logic            lo_q;
    logic [HI_W-1:0] hi_q;
    src_edges_t      edges;
    src_ctrl_t       ctrl;
    src_mode_e       mode;

    assign ext_in = {cnt_b_i, cnt_a_i};
    assign clr    = src_clear(clr_x_i, clr_y_i);
    assign mode   = src_mode_e'(chain_i);

    for (genvar g = 0; g < N_IN; g++) begin : g_ext_det
        src_fall_det u_det (
            .clk     (clk),
            .rst     (rst),
            .flush_i (1'b0),
            .din_i   (ext_in[g]),
            .fall_o  (ext_fall[g])
        );
    end

    src_fall_det u_lo_det (
        .clk     (clk),
        .rst     (rst),
        .flush_i (clr),
        .din_i   (lo_q),
        .fall_o  (edges.fall_q)
    );

    assign edges.fall_a = ext_fall[0];
    assign edges.fall_b = ext_fall[1];
    assign ctrl         = src_decode(mode, edges, clr);

    src_toggle_stage u_lo (
        .clk   (clk),
        .rst   (rst),
        .clr_i (ctrl.clear),
        .stb_i (ctrl.lo_stb),
        .q_o   (lo_q)
    );

    src_wrap_counter #(.W(HI_W)) u_hi (
        .clk   (clk),
        .rst   (rst),
        .clr_i (ctrl.clear),
        .stb_i (ctrl.hi_stb),
        .q_o   (hi_q)
    );

    assign q_o = Q_W'({hi_q, lo_q});
endmodule

// File: rtl/src_checker.sv
module src_checker #(
    parameter int unsigned HI_W = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          cnt_a_i,
    input logic          cnt_b_i,
    input logic          clr_x_i,
    input logic          clr_y_i,
    input logic          chain_i,
    input logic [HI_W:0] q_o
);
    logic            a_seen, b_seen, lo_seen;
    logic            clr;
    logic [HI_W-1:0] hi;

    assign clr = clr_x_i & clr_y_i;
    assign hi  = q_o[HI_W:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            a_seen  <= 1'b0;
            b_seen  <= 1'b0;
            lo_seen <= 1'b0;
        end else begin
            a_seen  <= cnt_a_i;
            b_seen  <= cnt_b_i;
            lo_seen <= clr ? 1'b0 : q_o[0];
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (q_o == '0));

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q_o == '0));

    assert_half_clear_counts_R5: assert property (@(posedge clk) disable iff (rst)
        ((clr_x_i ^ clr_y_i) && a_seen && !cnt_a_i) |=> (q_o[0] != $past(q_o[0])));

    assert_lo_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && a_seen && !cnt_a_i) |=> (q_o[0] != $past(q_o[0])));

    assert_lo_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(a_seen && !cnt_a_i)) |=> $stable(q_o[0]));

    assert_hi_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr && !chain_i && b_seen && !cnt_b_i) |=> (hi == HI_W'($past(hi) + 1'b1)));

    assert_hi_hold_split_R7: assert property (@(posedge clk) disable iff (rst)
        (!clr && !chain_i && !(b_seen && !cnt_b_i)) |=> $stable(hi));

    assert_chain_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr && chain_i && lo_seen && !q_o[0]) |=> (hi == HI_W'($past(hi) + 1'b1)));

    assert_chain_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!clr && chain_i && !(lo_seen && !q_o[0])) |=> $stable(hi));
endmodule

bind split_ripple_counter src_checker #(.HI_W(HI_W)) u_src_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt_a_i (cnt_a_i),
    .cnt_b_i (cnt_b_i),
    .clr_x_i (clr_x_i),
    .clr_y_i (clr_y_i),
    .chain_i (chain_i),
    .q_o     (q_o)
);

// File: tb/split_ripple_counter_tb_top.sv
`timescale 1ns/1ps
module split_ripple_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a = 1'b0, b = 1'b0, x = 1'b0, y = 1'b0, ch = 1'b0;
    logic [3:0] q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic       m_ap, m_bp, m_qp;
    logic [3:0] m_q;

    always #2.5 clk = ~clk;

    split_ripple_counter dut_i (
        .clk(clk), .rst(rst), .cnt_a_i(a), .cnt_b_i(b),
        .clr_x_i(x), .clr_y_i(y), .chain_i(ch), .q_o(q)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: q=%0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic clr, fa, fb, fq, stb;
        clr = x & y;
        fa  = m_ap & ~a;
        fb  = m_bp & ~b;
        fq  = m_qp & ~m_q[0];
        stb = ch ? fq : fb;
        if (rst) begin
            m_q = 4'd0; m_qp = 1'b0; m_ap = 1'b0; m_bp = 1'b0;
        end else begin
            if (clr) begin
                m_q  = 4'd0;
                m_qp = 1'b0;
            end else begin
                m_qp = m_q[0];
                if (fa)  m_q[0]   = ~m_q[0];
                if (stb) m_q[3:1] = m_q[3:1] + 3'd1;
            end
            m_ap = a;
            m_bp = b;
        end
    endtask

    task automatic cyc(input logic na, nb, nx, ny, nch);
        a = na; b = nb; x = nx; y = ny; ch = nch;
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic pulse(input logic pa, pb, px, py, pch);
        cyc(pa, pb, px, py, pch);
        cyc(1'b0, 1'b0, px, py, pch);
        cyc(1'b0, 1'b0, px, py, pch);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(0, 0, 0, 0, ch);
        cyc(0, 0, 0, 0, ch);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_q = 4'd0; m_qp = 1'b0; m_ap = 1'b0; m_bp = 1'b0;
        @(negedge clk);
        do_reset();
        chk("R1 reset state", q, 4'd0);

        // R2: five A pulses in split mode leave bit 0 set
        for (int i = 0; i < 5; i++) pulse(1, 0, 0, 0, 0);
        chk("R2 five A pulses", q, 4'b0001);

        // R3: eleven B pulses -> upper = 11 mod 8 = 3
        do_reset();
        for (int i = 0; i < 11; i++) pulse(0, 1, 0, 0, 0);
        chk("R3 eleven B pulses", q, 4'd6);

        // R8: both inputs toggling every clock, 7 falling edges each
        do_reset();
        for (int i = 0; i < 14; i++) cyc((i % 2) == 0, (i % 2) == 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R8 full-rate toggling", q, 4'b1111);
        for (int i = 0; i < 2; i++) pulse(0, 1, 0, 0, 0);
        chk("R3 upper wrap 7 to 0", q, 4'b0011);

        // R4: chained count follows pulse number modulo 16
        do_reset();
        ch = 1'b1;
        for (int i = 1; i <= 20; i++) begin
            pulse(1, 0, 0, 0, 1);
            chk("R4 chained count", q, 4'(i % 16));
        end

        // R7: B ignored in chained mode; low bit ignored by upper in split mode
        for (int i = 0; i < 3; i++) pulse(0, 1, 0, 0, 1);
        chk("R7 B ignored when chained", q, 4'd4);
        pulse(1, 0, 0, 0, 0);
        pulse(1, 0, 0, 0, 0);
        chk("R7 low fall ignored when split", q, 4'd4);

        // R5: a single clear input does not clear
        pulse(1, 0, 1, 0, 0);
        chk("R5 only x high still counts", q, 4'd5);
        pulse(1, 0, 0, 1, 0);
        chk("R5 only y high still counts", q, 4'd4);
        cyc(0, 0, 1, 1, 0);
        chk("R5 both high clears", q, 4'd0);

        // R6: edges inside clear are dropped; clearing bit 0 does not step upper
        do_reset();
        pulse(1, 0, 0, 0, 1);
        chk("R6 setup", q, 4'd1);
        cyc(1, 1, 1, 1, 1);
        cyc(0, 0, 1, 1, 1);
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 1);
        chk("R6 edges during clear discarded", q, 4'd0);

        // Random run against the bench model (R2 R3 R4 R5 R6 R7)
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            logic nch;
            nch = ($urandom_range(0, 49) == 0) ? ~ch : ch;
            cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                $urandom_range(0, 9) < 3, $urandom_range(0, 9) < 3, nch);
            chk("R2 R3 R4 R6 random vs model", q, m_q);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule